// File: doc/BRIEF.md
# Audio Link Frame Sync Tracker

This block follows the frame structure of a serial audio codec link. The link bit clock and the frame marker come in as plain inputs. The block samples both on a faster reference clock and finds each falling edge of the bit clock. It reads the marker level at those edges. The first high reading opens a frame that lasts 256 bit periods. The tracker then reports where the link is inside that frame: a 16-bit tag slot, followed by twelve data slots of 20 bits each.

The block also holds the link power-down state. A one-cycle request from the control logic puts the link into power-down. While the link is powered down the bit clock is stopped, so the block cannot rely on it. Instead it times the marker line on the reference clock. If the marker stays high for a minimum number of reference cycles, that is a warm-reset request. The power-down flag clears when the marker falls again. An active-low cold reset, synchronous to the reference clock, returns every piece of state to its default.

Top module: `alnk_frame_tracker`

## Requirements
- R1: After cold reset (`rst_n` low at a clock edge), `link_pd_o`, `frame_valid_o` and `frame_start_o` are 0, and `slot_o` and `bit_o` are 0.
- R2: While no frame is open, the first falling bit-clock edge at which the marker reads high opens a frame: `frame_valid_o` goes to 1, `slot_o`=0, `bit_o`=0, and `frame_start_o` pulses.
- R3: Inside a frame, each falling bit-clock edge advances the position by one. Slot 0 holds bits 0..15, and slots 1..12 each hold bits 0..19, so frame position p maps to slot 0 / bit p for p<16, and otherwise to slot (p-16)/20+1, bit (p-16)%20.
- R4: A high marker reading at frame positions 1 through 255 is ignored. It does not pulse `frame_start_o` and does not disturb the count.
- R5: At the edge that follows position 255 (slot 12, bit 19), a high marker reading opens a new frame at slot 0 / bit 0. A low reading closes the frame (`frame_valid_o`=0), and the tracker then waits for a high reading.
- R6: The marker is only read at falling bit-clock edges. A marker pulse that rises and falls while the bit clock stays high has no effect.
- R7: A one-cycle `pd_enter_i` pulse sets `link_pd_o` and closes any open frame. While `link_pd_o` is 1, bit-clock edges do not open frames, whatever the marker level.
- R8: While powered down, a marker that stays high for at least WARM_MIN reference cycles and then falls clears `link_pd_o`. A shorter high pulse leaves the link powered down. Once the flag clears, frames can open again.
- R9: When `pd_enter_i` lands in the same cycle that would finish a warm-reset release, power-down wins and `link_pd_o` stays 1.
- R10: `frame_start_o` is never high for two reference cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, faster than the bit clock |
| rst_n | input | 1 | Cold reset, active low, synchronous |
| bclk_i | input | 1 | Link bit clock, sampled on `clk` |
| mark_i | input | 1 | Frame marker and warm-reset line |
| pd_enter_i | input | 1 | One-cycle request to power down the link |
| frame_start_o | output | 1 | One-cycle strobe when a frame opens |
| frame_valid_o | output | 1 | A frame is open |
| slot_o | output | 4 | Slot index within the frame (0 = tag) |
| bit_o | output | 5 | Bit index within the current slot |
| link_pd_o | output | 1 | Link is powered down |

## Verification
Two functions can meet in the same reference cycle: the warm-reset release, which fires when the delayed marker goes low after a long enough hold, and a fresh power-down request. The bench holds the marker high well past WARM_MIN. It drops the marker, then counts the two synchronizer stages and raises `pd_enter_i` exactly on the edge where the release would take effect. A monitor watches `link_pd_o` across the whole window, and any single cycle at 0 is judged a failure. This catches both a wrong priority and a request that arrives off the critical edge. A second overlap is checked too: the restart of a frame at the end of position 255, when the marker is high on the very next edge, is compared with a plain close of the frame.

// File: rtl/alnk_pkg.sv
// Package: shared defaults and types for the audio link frame tracker.
// Assumes: frame layout is one tag slot followed by equal-width data slots.
package alnk_pkg;
    localparam int TAG_BITS_D  = 16;
    localparam int SLOT_BITS_D = 20;
    localparam int NUM_SLOTS_D = 12;
    localparam int WARM_MIN_D  = 16;
    localparam int SYNC_STG_D  = 2;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_RUN  = 1'b1
    } frame_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/alnk_sync.sv
// Module: multi-stage synchronizer for a bundle of slow asynchronous lines.
// Assumes: each line is stable for several reference cycles per change.
module alnk_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // First stage captures the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each further stage re-registers the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/alnk_frame_ctr.sv
// Module: frame position counter. Opens a frame on the first high marker read
// at a bit-clock fall and steps slot/bit counters through the frame.
// Assumes: bit_fall_i is a one-cycle pulse, never on two consecutive cycles.
module alnk_frame_ctr
    import alnk_pkg::*;
#(
    parameter int TAG_BITS  = TAG_BITS_D,
    parameter int SLOT_BITS = SLOT_BITS_D,
    parameter int NUM_SLOTS = NUM_SLOTS_D,
    localparam int BIT_W    = $clog2(max_int(TAG_BITS, SLOT_BITS)),
    localparam int SLOT_W   = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_fall_i,
    input  logic              mark_i,
    input  logic              halt_i,
    output logic              frame_start_o,
    output logic              frame_valid_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [BIT_W-1:0]  bit_o
);
    localparam logic [BIT_W-1:0]  TAG_LAST  = BIT_W'(TAG_BITS - 1);
    localparam logic [BIT_W-1:0]  SLOT_LAST = BIT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_W-1:0] SLOT_END  = SLOT_W'(NUM_SLOTS);

    frame_state_e      state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;
    logic              start_q;
    logic [BIT_W-1:0]  bit_last;
    logic              at_last;

    // Last bit index of the slot currently being counted.
    always_comb bit_last = (slot_q == '0) ? TAG_LAST : SLOT_LAST;

    // High on the final position of a frame.
    always_comb at_last = (slot_q == SLOT_END) && (bit_q == SLOT_LAST);

    // Frame state, position counters and frame-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            slot_q  <= '0;
            bit_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (halt_i) begin
                state_q <= FS_IDLE;
                slot_q  <= '0;
                bit_q   <= '0;
            end else if (bit_fall_i) begin
                if (state_q == FS_IDLE || at_last) begin
                    slot_q  <= '0;
                    bit_q   <= '0;
                    state_q <= mark_i ? FS_RUN : FS_IDLE;
                    start_q <= mark_i;
                end else if (bit_q == bit_last) begin
                    bit_q  <= '0;
                    slot_q <= slot_q + 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    assign frame_start_o = start_q;
    assign frame_valid_o = (state_q == FS_RUN);
    assign slot_o        = slot_q;
    assign bit_o         = bit_q;

    // R2: a new frame opens at the first position.
    a_r2_start_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (frame_valid_o && slot_q == '0 && bit_q == '0));
    // R3: bit index stays inside the length of its slot.
    a_r3_bit_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == '0) ? (bit_q <= TAG_LAST) : (bit_q <= SLOT_LAST));
    // R3: slot index never passes the last data slot.
    a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= SLOT_END);
    // R4: a frame opens only from idle or from the final position.
    a_r4_no_midframe_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> $past(state_q == FS_IDLE || at_last));
    // R10: frame-start strobe lasts one cycle.
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
endmodule

// File: rtl/alnk_pd_ctl.sv
// Module: link power-down flag with warm-reset detection on the marker line.
// Assumes: bit clock is stopped during power-down, so the marker hold time
// is measured in reference-clock cycles.
module alnk_pd_ctl #(
    parameter int WARM_MIN = alnk_pkg::WARM_MIN_D,
    localparam int CNT_W   = $clog2(WARM_MIN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_i,
    input  logic pd_enter_i,
    output logic link_pd_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WARM_MIN);

    logic             pd_q;
    logic [CNT_W-1:0] hold_q;
    logic             wake;

    // Release fires when an armed hold ends with the marker falling.
    always_comb wake = pd_q && !mark_i && (hold_q == CNT_MAX);

    // Saturating count of marker-high cycles while powered down.
    always_ff @(posedge clk) begin
        if (!rst_n)                        hold_q <= '0;
        else if (!pd_q || !mark_i)         hold_q <= '0;
        else if (hold_q != CNT_MAX)        hold_q <= hold_q + 1'b1;
    end

    // Power-down flag: a new request has priority over a release.
    always_ff @(posedge clk) begin
        if (!rst_n)          pd_q <= 1'b0;
        else if (pd_enter_i) pd_q <= 1'b1;
        else if (wake)       pd_q <= 1'b0;
    end

    assign link_pd_o = pd_q;

    // R9: a power-down request always leaves the link powered down.
    a_r9_enter_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pd_enter_i |=> pd_q);
    // R8: release only after a full hold.
    a_r8_release_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_q) |-> ($past(hold_q) == CNT_MAX));
    // R8: release only with the marker low.
    a_r8_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_q) |-> !$past(mark_i));
endmodule

// File: rtl/alnk_frame_tracker.sv
// Module: top of the audio link frame tracker. Oversamples bit clock and
// marker, finds falling bit-clock edges, and combines frame counting with
// power-down control.
// Assumes: clk is several times faster than bclk_i; rst_n is synchronous.
module alnk_frame_tracker
    import alnk_pkg::*;
#(
    parameter int TAG_BITS  = TAG_BITS_D,
    parameter int SLOT_BITS = SLOT_BITS_D,
    parameter int NUM_SLOTS = NUM_SLOTS_D,
    parameter int WARM_MIN  = WARM_MIN_D,
    parameter int SYNC_STG  = SYNC_STG_D,
    localparam int BIT_W    = $clog2(max_int(TAG_BITS, SLOT_BITS)),
    localparam int SLOT_W   = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              mark_i,
    input  logic              pd_enter_i,
    output logic              frame_start_o,
    output logic              frame_valid_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [BIT_W-1:0]  bit_o,
    output logic              link_pd_o
);
    logic [1:0] sync_q;
    logic       bclk_s;
    logic       mark_s;
    logic       bclk_d;
    logic       bit_fall;
    logic       halt;

    alnk_sync #(.W(2), .STAGES(SYNC_STG)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bclk_i, mark_i}),
        .q_o   (sync_q)
    );

    assign bclk_s = sync_q[1];
    assign mark_s = sync_q[0];

    // Delayed bit clock for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_s;
    end

    // One-cycle pulse on each falling bit-clock edge.
    always_comb bit_fall = bclk_d && !bclk_s;

    // Frame counting stops while powered down or entering power-down.
    always_comb halt = link_pd_o || pd_enter_i;

    alnk_frame_ctr #(
        .TAG_BITS  (TAG_BITS),
        .SLOT_BITS (SLOT_BITS),
        .NUM_SLOTS (NUM_SLOTS)
    ) i_frame_ctr (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_fall_i    (bit_fall),
        .mark_i        (mark_s),
        .halt_i        (halt),
        .frame_start_o (frame_start_o),
        .frame_valid_o (frame_valid_o),
        .slot_o        (slot_o),
        .bit_o         (bit_o)
    );

    alnk_pd_ctl #(.WARM_MIN(WARM_MIN)) i_pd_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark_i     (mark_s),
        .pd_enter_i (pd_enter_i),
        .link_pd_o  (link_pd_o)
    );

    // R7: no frame stays open while the link is powered down.
    a_r7_pd_blocks_frame: assert property (@(posedge clk) disable iff (!rst_n)
        link_pd_o |-> !frame_valid_o);
    // R7: no frame opens while powered down.
    a_r7_no_start_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
        link_pd_o |-> !frame_start_o);
endmodule

// File: tb/test_alnk_frame_tracker.sv
module test_alnk_frame_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0;
    logic       mark = 1'b0;
    logic       pd_enter = 1'b0;
    logic       frame_start, frame_valid, link_pd;
    logic [3:0] slot;
    logic [4:0] bitx;

    int checks = 0, failures = 0;
    int fs_count = 0, exp_fs = 0;
    bit fs_wide = 0, prev_fs = 0;
    bit pd_watch = 0, pd_drop = 0;
    bit done = 0;
    bit exp_valid = 0;
    int exp_pos = 0;

    always #4 clk = ~clk;

    alnk_frame_tracker i_alnk_frame_tracker (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .mark_i(mark),
        .pd_enter_i(pd_enter), .frame_start_o(frame_start),
        .frame_valid_o(frame_valid), .slot_o(slot), .bit_o(bitx),
        .link_pd_o(link_pd)
    );

    // Monitor of strobe count/width and of power-down drops in a window.
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_start) fs_count++;
            if (frame_start && prev_fs) fs_wide = 1;
            if (pd_watch && !link_pd) pd_drop = 1;
        end
        prev_fs = frame_start;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One bit period; marker changes while the bit clock is high.
    task automatic bit_step(input logic m);
        @(negedge clk);
        mark = m;
        bclk = 1'b1;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
        repeat (5) @(negedge clk);
        if (!link_pd) begin
            if (!exp_valid || exp_pos == 255) begin
                exp_valid = m;
                exp_pos = 0;
                if (m) exp_fs++;
            end else exp_pos++;
        end
    endtask

    task automatic check_pos(input string req);
        int es, eb;
        if (exp_pos < 16) begin es = 0; eb = exp_pos; end
        else begin es = (exp_pos - 16) / 20 + 1; eb = (exp_pos - 16) % 20; end
        check(req, frame_valid, int'(exp_valid));
        if (exp_valid) begin
            check(req, slot, es);
            check(req, bitx, eb);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 pd", link_pd, 0);
        check("R1 valid", frame_valid, 0);
        check("R1 start", frame_start, 0);
        check("R1 slot", slot, 0);
        check("R1 bit", bitx, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_frame;
        for (int i = 0; i < 3; i++) bit_step(1'b0);
        check("R2 idle", frame_valid, 0);
        bit_step(1'b1);
        check_pos("R2 open");
        check("R2 strobe", fs_count, exp_fs);
    endtask

    // Rest of a frame with marker high for 16 bits, plus a stray pulse.
    task automatic t_rest_of_frame(input int stray);
        for (int k = 1; k < 256; k++) begin
            bit_step((k < 16) || (k == stray));
            check_pos("R3 position");
        end
        check("R4 no midframe start", fs_count, exp_fs);
    endtask

    task automatic t_wrap;
        bit_step(1'b1);
        check_pos("R5 restart");
        check("R5 restart strobe", fs_count, exp_fs);
        t_rest_of_frame(-1);
        bit_step(1'b0);
        check("R5 close", frame_valid, 0);
        bit_step(1'b0);
        check("R5 stay closed", frame_valid, 0);
    endtask

    task automatic t_between_edges;
        @(negedge clk);
        bclk = 1'b1;
        repeat (2) @(negedge clk);
        mark = 1'b1;
        repeat (3) @(negedge clk);
        mark = 1'b0;
        repeat (4) @(negedge clk);
        bclk = 1'b0;
        repeat (6) @(negedge clk);
        check("R6 valid", frame_valid, 0);
        check("R6 strobe", fs_count, exp_fs);
    endtask

    task automatic pulse_pd;
        @(negedge clk);
        pd_enter = 1'b1;
        @(negedge clk);
        pd_enter = 1'b0;
    endtask

    task automatic t_power_down;
        bit_step(1'b1);
        check("R7 pre frame", frame_valid, 1);
        pulse_pd();
        exp_valid = 0;
        check("R7 pd set", link_pd, 1);
        check("R7 frame closed", frame_valid, 0);
        bit_step(1'b1);
        @(negedge clk);
        mark = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 no frame", frame_valid, 0);
        check("R7 no strobe", fs_count, exp_fs);
        check("R7 still pd", link_pd, 1);
    endtask

    task automatic t_warm;
        @(negedge clk);
        mark = 1'b1;
        repeat (4) @(negedge clk);
        mark = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 short hold", link_pd, 1);
        mark = 1'b1;
        repeat (24) @(negedge clk);
        check("R8 pd while high", link_pd, 1);
        mark = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 released", link_pd, 0);
        bit_step(1'b1);
        check("R8 frame after wake", frame_valid, 1);
        check("R8 strobe after wake", fs_count, exp_fs);
    endtask

    task automatic t_collision;
        pulse_pd();
        exp_valid = 0;
        pd_watch = 1;
        mark = 1'b1;
        repeat (24) @(negedge clk);
        mark = 1'b0;
        repeat (2) @(negedge clk);
        pd_enter = 1'b1;
        @(negedge clk);
        pd_enter = 1'b0;
        repeat (6) @(negedge clk);
        pd_watch = 0;
        check("R9 never dropped", int'(pd_drop), 0);
        check("R9 still pd", link_pd, 1);
    endtask

    initial begin
        t_reset();
        t_first_frame();
        t_rest_of_frame(100);
        t_wrap();
        t_between_edges();
        t_power_down();
        t_warm();
        t_collision();
        check("R10 single-cycle strobe", int'(fs_wide), 0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule